// File: doc/BRIEF.md
# PCI IDE configuration register file

This block is the configuration space of function 0 of a two-channel PCI IDE controller. An external configuration agent reaches it through a byte-wide access port: an 8-bit offset, a function number, separate read and write strobes, write data and registered read data. The block returns identification constants. It holds the command register, the upper status byte, the programming-interface byte, four channel base registers, the bus-master base and a bank of vendor control bytes. It latches one interrupt-status bit per channel from two event inputs.

Each register applies its own write rule. These rules include fixed bit masks, forced-one bits, write-one-to-clear bits and writes that are gated by a capability or lock bit. The two interrupt-status bits clear when their register is read. Two parameters select the variant. `NATIVE_MODE` makes the base registers writable and loads native-mode addresses at reset. `SINGLE_CHANNEL` removes the secondary channel. The decoded command, interface, lock, channel-enable and base values are driven out continuously to a separate address decoder.

The access port has no back-pressure. A strobe is accepted in the cycle it is presented. Read data appears one cycle after the read strobe and is held until the next read. A read and a write in the same cycle return the value from before the write.

Top module: `pci_ide_cfg_regs`

## Requirements
- R1: Reads return read-only identification bytes, and writes do not change them: 0x00/0x01 = vendor ID 0x1095 (low byte first), 0x02/0x03 = device ID 0x0646, 0x06 = 0x80, 0x0A = 0x01, 0x0B = 0x01, 0x3C = 0x0E, 0x3D = 0x01, 0x3E = 0x02, 0x3F = 0x04.
- R2: The command byte at 0x04 resets to 0 and stores only the write bits selected by 0x45.
- R3: The status byte at 0x07 resets to 0x02. A write clears each bit where both the data and the mask 0xB1 hold a 1, and no other bit changes.
- R4: The interface byte at 0x09 resets to 0x8A in native mode and 0x80 otherwise. A write changes only bits 0 and 2, and only while bits 1 and 3 both read 1.
- R5: The base bytes at 0x10/0x11, 0x14/0x15, 0x18/0x19 and 0x1C/0x1D accept writes only while bit 6 of 0x50 is 1. A low byte stores the data masked with 0xF8 (at 0x10 and 0x18) or 0xFC (at 0x14 and 0x1C), with bit 0 forced to 1.
- R6: The bus-master base low byte at 0x20 resets to 0x01 and stores (data & 0xF0) | 0x01. The high byte at 0x21 is fully writable.
- R7: Vendor write masks are: 0x51 → 0xC8; 0x53 and 0x55 → 0xC0; 0x52, 0x54, 0x56, 0x58, 0x59 and 0x5B → 0xFF; 0x57 → 0xCC. A write to 0x57 leaves its bit 4 unchanged.
- R8: A primary event sets bit 2 of 0x50. A function-0 read of 0x50 returns the current value and then clears that bit. An event in the same cycle as the read leaves the bit set.
- R9: A secondary event sets bit 4 of 0x57, and this bit clears on read in the same way. When an event arrives in the same cycle as a read or write of 0x57, the event wins. Single-channel builds ignore secondary events.
- R10: Native-mode reset loads 0x50 = 0x40 and the bases 0x01F1, 0x03F5, 0x0171 and 0x0375. Legacy reset loads 0x50 = 0 and zero bases. Every variant loads 0x57 = 0x0C and 0x59 = 0x40. It loads 0x51 = 0x08 when both channels are built, and 0 when only one is.
- R11: Offsets with no register, including 0x5A and 0x70–0x7F, read 0 and ignore writes.
- R12: When the function number is not 0, a read returns 0xFF and a write changes nothing.
- R13: `cfg_rdata` resets to 0, is loaded on the clock edge that samples `cfg_rd`, and holds while `cfg_rd` is low.
- R14: The exported values are continuous. `cmd_out` = 0x04 and `progif_out` = 0x09. `base_wr_en` = bit 6 of 0x50 and `sec_chan_en` = bit 3 of 0x51. Each base output is {high byte, low byte with its mask applied}, and `bm_base` = {0x21, 0x20 & 0xF0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_func | input | 3 | Function number of the access |
| cfg_addr | input | 8 | Byte offset |
| cfg_wr | input | 1 | Write strobe, one access per cycle |
| cfg_wdata | input | 8 | Write data |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Registered read data |
| irq_ev_pri | input | 1 | Primary channel interrupt event |
| irq_ev_sec | input | 1 | Secondary channel interrupt event |
| cmd_out | output | 8 | Command byte |
| progif_out | output | 8 | Programming-interface byte |
| base_wr_en | output | 1 | Base registers unlocked |
| sec_chan_en | output | 1 | Secondary channel enable |
| pri_cmd_base | output | 16 | Primary command-block base |
| pri_ctl_base | output | 16 | Primary control-block base |
| sec_cmd_base | output | 16 | Secondary command-block base |
| sec_ctl_base | output | 16 | Secondary control-block base |
| bm_base | output | 16 | Bus-master base |

## Verification
The bench targets the read that clears an interrupt bit in the same cycle that an event sets it. A design that clears first would lose that interrupt, and the next read of the register would come back empty. The bench also writes 0x57 while bit 4 is pending; a design that overwrote the whole byte would drop the pending interrupt. It checks the locked bases and the locked interface byte in the legacy variant; a missing lock would let a write move the decoded addresses. It also checks the forced-one and masked low bytes, nonzero function numbers, and unimplemented offsets such as 0x5A, where a loose decode would store data.

// File: rtl/pide_cfg_pkg.sv
package pide_cfg_pkg;

  localparam int BYTE_W    = 8;
  localparam int NUM_BASES = 4;
  localparam int VEND_LO   = 'h51;
  localparam int VEND_HI   = 'h5B;
  localparam int VEND_CNT  = VEND_HI - VEND_LO + 1;

  localparam logic [7:0] A_CMD      = 8'h04;
  localparam logic [7:0] A_STAT_HI  = 8'h07;
  localparam logic [7:0] A_PROGIF   = 8'h09;
  localparam logic [7:0] A_BASE0    = 8'h10;
  localparam logic [7:0] A_BM_LO    = 8'h20;
  localparam logic [7:0] A_BM_HI    = 8'h21;
  localparam logic [7:0] A_CHAN_CTL = 8'h50;
  localparam logic [7:0] A_SEC_IRQ  = 8'h57;

  localparam logic [7:0] CMD_KEEP   = 8'h45;
  localparam logic [7:0] STAT_W1C   = 8'hB1;
  localparam logic [7:0] PROGIF_WR  = 8'h05;
  localparam logic [7:0] PROGIF_CAP = 8'h0A;
  localparam logic [7:0] BM_LO_KEEP = 8'hF0;
  localparam int         PRI_IRQ_BIT = 2;
  localparam int         SEC_IRQ_BIT = 4;
  localparam int         UNLOCK_BIT  = 6;

  function automatic logic [7:0] vend_mask(input int off);
    case (off)
      'h51:                         return 8'hC8;
      'h53, 'h55:                   return 8'hC0;
      'h57:                         return 8'hCC;
      'h52, 'h54, 'h56, 'h58, 'h59, 'h5B: return 8'hFF;
      default:                      return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] vend_reset(input int off, input bit single);
    case (off)
      'h51:    return single ? 8'h00 : 8'h08;
      'h57:    return 8'h0C;
      'h59:    return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] base_reset(input int idx, input bit native);
    if (!native) return 16'h0000;
    case (idx)
      0:       return 16'h01F1;
      1:       return 16'h03F5;
      2:       return 16'h0171;
      default: return 16'h0375;
    endcase
  endfunction

  function automatic logic [7:0] base_lo_keep(input int idx);
    return (idx % 2 == 1) ? 8'hFC : 8'hF8;
  endfunction

endpackage

// File: rtl/pide_ident_rom.sv
module pide_ident_rom #(
  parameter logic [15:0] VENDOR_ID = 16'h1095,
  parameter logic [15:0] DEVICE_ID = 16'h0646
) (
  input  logic [7:0] addr,
  output logic       hit,
  output logic [7:0] data
);
  always_comb begin
    hit  = 1'b1;
    data = 8'h00;
    case (addr)
      8'h00:   data = VENDOR_ID[7:0];
      8'h01:   data = VENDOR_ID[15:8];
      8'h02:   data = DEVICE_ID[7:0];
      8'h03:   data = DEVICE_ID[15:8];
      8'h06:   data = 8'h80;
      8'h0A:   data = 8'h01;
      8'h0B:   data = 8'h01;
      8'h3C:   data = 8'h0E;
      8'h3D:   data = 8'h01;
      8'h3E:   data = 8'h02;
      8'h3F:   data = 8'h04;
      default: hit  = 1'b0;
    endcase
  end
endmodule

// File: rtl/pide_base_bank.sv
module pide_base_bank
  import pide_cfg_pkg::*;
#(
  parameter bit NATIVE_MODE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_ok,
  input  logic                    unlock,
  input  logic [7:0]              addr,
  input  logic [7:0]              wdata,
  output logic                    rd_hit,
  output logic [7:0]              rd_data,
  output logic [16*NUM_BASES-1:0] bases
);
  logic       hit_v  [NUM_BASES];
  logic [7:0] data_v [NUM_BASES];

  for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
    localparam logic [7:0]  LO_A = 8'(A_BASE0 + 4 * g);
    localparam logic [7:0]  HI_A = 8'(A_BASE0 + 4 * g + 1);
    localparam logic [7:0]  KEEP = base_lo_keep(g);
    localparam logic [15:0] RST  = base_reset(g, NATIVE_MODE);
    logic [7:0] lo_q, hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= RST[7:0];
        hi_q <= RST[15:8];
      end else if (wr_ok && unlock) begin
        if (addr == LO_A) lo_q <= (wdata & KEEP) | 8'h01;
        if (addr == HI_A) hi_q <= wdata;
      end
    end

    assign hit_v[g]  = (addr == LO_A) || (addr == HI_A);
    assign data_v[g] = (addr == LO_A) ? lo_q : hi_q;
    assign bases[16*g +: 16] = {hi_q, lo_q & KEEP};
  end

  always_comb begin
    rd_hit  = 1'b0;
    rd_data = 8'h00;
    for (int i = 0; i < NUM_BASES; i++) begin
      if (hit_v[i]) begin
        rd_hit  = 1'b1;
        rd_data = data_v[i];
      end
    end
  end
endmodule

// File: rtl/pide_irq_latch.sv
module pide_irq_latch #(
  parameter bit SINGLE_CHANNEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_pri,
  input  logic ev_sec,
  input  logic clr_pri,
  input  logic clr_sec,
  output logic pri_flag,
  output logic sec_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pri_flag <= 1'b0;
    else        pri_flag <= ev_pri | (pri_flag & ~clr_pri);
  end

  if (SINGLE_CHANNEL) begin : g_one
    logic unused_sec;
    assign unused_sec = ev_sec ^ clr_sec;
    assign sec_flag   = 1'b0;
  end else begin : g_two
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sec_flag <= 1'b0;
      else        sec_flag <= ev_sec | (sec_flag & ~clr_sec);
    end
  end
endmodule

// File: rtl/pci_ide_cfg_regs.sv
module pci_ide_cfg_regs
  import pide_cfg_pkg::*;
#(
  parameter bit          NATIVE_MODE    = 1'b1,
  parameter bit          SINGLE_CHANNEL = 1'b0,
  parameter logic [15:0] VENDOR_ID      = 16'h1095,
  parameter logic [15:0] DEVICE_ID      = 16'h0646
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_func,
  input  logic [7:0]  cfg_addr,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_wdata,
  input  logic        cfg_rd,
  output logic [7:0]  cfg_rdata,
  input  logic        irq_ev_pri,
  input  logic        irq_ev_sec,
  output logic [7:0]  cmd_out,
  output logic [7:0]  progif_out,
  output logic        base_wr_en,
  output logic        sec_chan_en,
  output logic [15:0] pri_cmd_base,
  output logic [15:0] pri_ctl_base,
  output logic [15:0] sec_cmd_base,
  output logic [15:0] sec_ctl_base,
  output logic [15:0] bm_base
);
  localparam logic [7:0] PROGIF_RST = NATIVE_MODE ? 8'h8A : 8'h80;
  localparam logic       UNLOCKED   = NATIVE_MODE;

  logic       fn0, wr_ok, rd_ok;
  logic       id_hit, base_hit;
  logic [7:0] id_data, base_data, rd_mux;
  logic [7:0] cmd_q, stat_hi_q, progif_q, bm_lo_q, bm_hi_q;
  logic [7:0] chan_ctl;
  logic       pri_flag, sec_flag;
  logic [16*NUM_BASES-1:0] bases;
  logic [7:0] vend_q [VEND_CNT];

  assign fn0   = (cfg_func == 3'd0);
  assign wr_ok = cfg_wr & fn0;
  assign rd_ok = cfg_rd & fn0;

  pide_ident_rom #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) u_id (
    .addr(cfg_addr), .hit(id_hit), .data(id_data)
  );

  pide_base_bank #(.NATIVE_MODE(NATIVE_MODE)) u_bases (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .unlock(UNLOCKED),
    .addr(cfg_addr), .wdata(cfg_wdata),
    .rd_hit(base_hit), .rd_data(base_data), .bases(bases)
  );

  pide_irq_latch #(.SINGLE_CHANNEL(SINGLE_CHANNEL)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .ev_pri(irq_ev_pri), .ev_sec(irq_ev_sec),
    .clr_pri(rd_ok && cfg_addr == A_CHAN_CTL),
    .clr_sec(rd_ok && cfg_addr == A_SEC_IRQ),
    .pri_flag(pri_flag), .sec_flag(sec_flag)
  );

  // Core registers with their individual write rules
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= 8'h00;
      stat_hi_q <= 8'h02;
      progif_q  <= PROGIF_RST;
      bm_lo_q   <= 8'h01;
      bm_hi_q   <= 8'h00;
    end else if (wr_ok) begin
      case (cfg_addr)
        A_CMD:     cmd_q     <= cfg_wdata & CMD_KEEP;
        A_STAT_HI: stat_hi_q <= stat_hi_q & ~(cfg_wdata & STAT_W1C);
        A_PROGIF:
          if ((progif_q & PROGIF_CAP) == PROGIF_CAP)
            progif_q <= (progif_q & ~PROGIF_WR) | (cfg_wdata & PROGIF_WR);
        A_BM_LO:   bm_lo_q   <= (cfg_wdata & BM_LO_KEEP) | 8'h01;
        A_BM_HI:   bm_hi_q   <= cfg_wdata;
        default: ;
      endcase
    end
  end

  // Vendor control bank, one masked byte per offset
  for (genvar g = 0; g < VEND_CNT; g++) begin : g_vend
    localparam logic [7:0] OFF  = 8'(VEND_LO + g);
    localparam logic [7:0] KEEP = vend_mask(VEND_LO + g);
    localparam logic [7:0] RST  = vend_reset(VEND_LO + g, SINGLE_CHANNEL);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       vend_q[g] <= RST;
      else if (wr_ok && cfg_addr == OFF) vend_q[g] <= (vend_q[g] & ~KEEP) | (cfg_wdata & KEEP);
    end
  end

  always_comb begin
    chan_ctl              = 8'h00;
    chan_ctl[UNLOCK_BIT]  = UNLOCKED;
    chan_ctl[PRI_IRQ_BIT] = pri_flag;
  end

  always_comb begin
    rd_mux = 8'h00;
    if (!fn0)          rd_mux = 8'hFF;
    else if (id_hit)   rd_mux = id_data;
    else if (base_hit) rd_mux = base_data;
    else begin
      case (cfg_addr)
        A_CMD:      rd_mux = cmd_q;
        A_STAT_HI:  rd_mux = stat_hi_q;
        A_PROGIF:   rd_mux = progif_q;
        A_BM_LO:    rd_mux = bm_lo_q;
        A_BM_HI:    rd_mux = bm_hi_q;
        A_CHAN_CTL: rd_mux = chan_ctl;
        default: begin
          for (int i = 0; i < VEND_CNT; i++) begin
            if (cfg_addr == 8'(VEND_LO + i)) rd_mux = vend_q[i];
          end
          if (cfg_addr == A_SEC_IRQ) rd_mux[SEC_IRQ_BIT] = sec_flag;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_rdata <= 8'h00;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

  assign cmd_out      = cmd_q;
  assign progif_out   = progif_q;
  assign base_wr_en   = chan_ctl[UNLOCK_BIT];
  assign sec_chan_en  = vend_q[0][3];
  assign pri_cmd_base = bases[15:0];
  assign pri_ctl_base = bases[31:16];
  assign sec_cmd_base = bases[47:32];
  assign sec_ctl_base = bases[63:48];
  assign bm_base      = {bm_hi_q, bm_lo_q & BM_LO_KEEP};
endmodule

// File: rtl/pide_cfg_chk.sv
module pide_cfg_chk #(
  parameter bit SINGLE_CHANNEL = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  cfg_func,
  input logic [7:0]  cfg_addr,
  input logic        cfg_wr,
  input logic        cfg_rd,
  input logic [7:0]  cfg_rdata,
  input logic        irq_ev_pri,
  input logic        irq_ev_sec,
  input logic [7:0]  cmd_out,
  input logic [7:0]  progif_out,
  input logic        base_wr_en,
  input logic [15:0] pri_cmd_base,
  input logic [15:0] sec_ctl_base
);
  AST_CMD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out & 8'hBA) == 8'h00); // R2

  AST_PROGIF_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !(progif_out[1] && progif_out[3]) |=> $stable(progif_out)); // R4

  AST_BASE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !base_wr_en |=> ($stable(pri_cmd_base) && $stable(sec_ctl_base))); // R5

  AST_PRI_IRQ_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ev_pri ##1 (cfg_rd && cfg_func == 3'd0 && cfg_addr == 8'h50) |=> cfg_rdata[2]); // R8

  AST_SEC_IRQ_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!SINGLE_CHANNEL && irq_ev_sec) ##1 (cfg_rd && cfg_func == 3'd0 && cfg_addr == 8'h57)
    |=> cfg_rdata[4]); // R9

  AST_OTHER_FUNC_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_func != 3'd0) |=> cfg_rdata == 8'hFF); // R12

  AST_OTHER_FUNC_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_func != 3'd0) |=> ($stable(cmd_out) && $stable(progif_out))); // R12

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> $stable(cfg_rdata)); // R13
endmodule

bind pci_ide_cfg_regs pide_cfg_chk #(.SINGLE_CHANNEL(SINGLE_CHANNEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
  .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
  .irq_ev_pri(irq_ev_pri), .irq_ev_sec(irq_ev_sec),
  .cmd_out(cmd_out), .progif_out(progif_out), .base_wr_en(base_wr_en),
  .pri_cmd_base(pri_cmd_base), .sec_ctl_base(sec_ctl_base)
);

// File: tb/pci_ide_cfg_regs_tb.sv
`timescale 1ns/1ps
module pci_ide_cfg_regs_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] func = 3'd0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic wr = 1'b0, rd = 1'b0, evp = 1'b0, evs = 1'b0;
  int total = 0, bad = 0;
  bit chk_on = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  logic [7:0]  rdata [2], cmd [2], pif [2];
  logic        bwe [2], sce [2];
  logic [15:0] pcb [2], pkb [2], scb [2], skb [2], bmb [2];

  pci_ide_cfg_regs #(.NATIVE_MODE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_func(func), .cfg_addr(addr), .cfg_wr(wr),
    .cfg_wdata(wdata), .cfg_rd(rd), .cfg_rdata(rdata[0]), .irq_ev_pri(evp),
    .irq_ev_sec(evs), .cmd_out(cmd[0]), .progif_out(pif[0]), .base_wr_en(bwe[0]),
    .sec_chan_en(sce[0]), .pri_cmd_base(pcb[0]), .pri_ctl_base(pkb[0]),
    .sec_cmd_base(scb[0]), .sec_ctl_base(skb[0]), .bm_base(bmb[0]));

  pci_ide_cfg_regs #(.NATIVE_MODE(1'b0)) u_leg (
    .clk(clk), .rst_n(rst_n), .cfg_func(func), .cfg_addr(addr), .cfg_wr(wr),
    .cfg_wdata(wdata), .cfg_rd(rd), .cfg_rdata(rdata[1]), .irq_ev_pri(evp),
    .irq_ev_sec(evs), .cmd_out(cmd[1]), .progif_out(pif[1]), .base_wr_en(bwe[1]),
    .sec_chan_en(sce[1]), .pri_cmd_base(pcb[1]), .pri_ctl_base(pkb[1]),
    .sec_cmd_base(scb[1]), .sec_ctl_base(skb[1]), .bm_base(bmb[1]));

  // Behavioural reference: index 0 native variant, index 1 legacy variant
  logic [7:0] m [0:1][0:255];
  logic [7:0] mrd [2];

  function automatic void minit(int v);
    for (int i = 0; i < 256; i++) m[v][i] = 8'h00;
    m[v]['h00] = 8'h95; m[v]['h01] = 8'h10; m[v]['h02] = 8'h46; m[v]['h03] = 8'h06;
    m[v]['h06] = 8'h80; m[v]['h07] = 8'h02; m[v]['h0A] = 8'h01; m[v]['h0B] = 8'h01;
    m[v]['h09] = (v == 0) ? 8'h8A : 8'h80;
    if (v == 0) begin
      m[v]['h50] = 8'h40;
      m[v]['h10] = 8'hF1; m[v]['h11] = 8'h01; m[v]['h14] = 8'hF5; m[v]['h15] = 8'h03;
      m[v]['h18] = 8'h71; m[v]['h19] = 8'h01; m[v]['h1C] = 8'h75; m[v]['h1D] = 8'h03;
    end
    m[v]['h20] = 8'h01; m[v]['h3C] = 8'h0E; m[v]['h3D] = 8'h01; m[v]['h3E] = 8'h02;
    m[v]['h3F] = 8'h04; m[v]['h51] = 8'h08; m[v]['h57] = 8'h0C; m[v]['h59] = 8'h40;
    mrd[v] = 8'h00;
  endfunction

  function automatic void mwrite(int v, logic [7:0] a, logic [7:0] d);
    bit open;
    open = m[v]['h50][6];
    case (a)
      8'h04: m[v][a] = d & 8'h45;
      8'h07: m[v][a] = m[v][a] & ~(d & 8'hB1);
      8'h09: if ((m[v][a] & 8'h0A) == 8'h0A) m[v][a] = (m[v][a] & 8'hFA) | (d & 8'h05);
      8'h10, 8'h18: if (open) m[v][a] = (d & 8'hF8) | 8'h01;
      8'h14, 8'h1C: if (open) m[v][a] = (d & 8'hFC) | 8'h01;
      8'h11, 8'h15, 8'h19, 8'h1D: if (open) m[v][a] = d;
      8'h20: m[v][a] = (d & 8'hF0) | 8'h01;
      8'h21, 8'h52, 8'h54, 8'h56, 8'h58, 8'h59, 8'h5B: m[v][a] = d;
      8'h51: m[v][a] = d & 8'hC8;
      8'h53, 8'h55: m[v][a] = d & 8'hC0;
      8'h57: m[v][a] = (m[v][a] & 8'h10) | (d & 8'hCC);
      default: ;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) begin
      if (!rst_n) minit(v);
      else begin
        if (rd) begin
          mrd[v] = (func != 3'd0) ? 8'hFF : m[v][addr];
          if (func == 3'd0 && addr == 8'h50) m[v]['h50][2] = 1'b0;
          if (func == 3'd0 && addr == 8'h57) m[v]['h57][4] = 1'b0;
        end
        if (wr && func == 3'd0) mwrite(v, addr, wdata);
        if (evp) m[v]['h50][2] = 1'b1;
        if (evs) m[v]['h57][4] = 1'b1;
      end
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    if (chk_on) begin
      for (int v = 0; v < 2; v++) begin
        chk("R13 read data", {8'h00, rdata[v]}, {8'h00, mrd[v]});
        chk("R14 cmd_out", {8'h00, cmd[v]}, {8'h00, m[v]['h04]});
        chk("R14 progif_out", {8'h00, pif[v]}, {8'h00, m[v]['h09]});
        chk("R14 lock/enable", {14'h0, bwe[v], sce[v]}, {14'h0, m[v]['h50][6], m[v]['h51][3]});
        chk("R14 pri cmd base", pcb[v], {m[v]['h11], m[v]['h10] & 8'hF8});
        chk("R14 pri ctl base", pkb[v], {m[v]['h15], m[v]['h14] & 8'hFC});
        chk("R14 sec cmd base", scb[v], {m[v]['h19], m[v]['h18] & 8'hF8});
        chk("R14 sec ctl base", skb[v], {m[v]['h1D], m[v]['h1C] & 8'hFC});
        chk("R14 bm base", bmb[v], {m[v]['h21], m[v]['h20] & 8'hF0});
      end
    end
  end

  task automatic do_wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d,
                       input logic es);
    @(negedge clk); func = f; addr = a; wdata = d; wr = 1'b1; evs = es;
    @(negedge clk); wr = 1'b0; evs = 1'b0; func = 3'd0;
  endtask

  task automatic do_rd(input logic [2:0] f, input logic [7:0] a, input logic ep,
                       input logic es, output logic [7:0] rn, output logic [7:0] rl);
    @(negedge clk); func = f; addr = a; rd = 1'b1; evp = ep; evs = es;
    @(negedge clk); rd = 1'b0; evp = 1'b0; evs = 1'b0; func = 3'd0;
    rn = rdata[0]; rl = rdata[1];
  endtask

  task automatic expect_rd(string req, logic [7:0] a, logic [7:0] en, logic [7:0] el);
    logic [7:0] rn, rl;
    do_rd(3'd0, a, 1'b0, 1'b0, rn, rl);
    chk(req, {8'h00, rn}, {8'h00, en});
    chk(req, {8'h00, rl}, {8'h00, el});
  endtask

  task automatic pulse(input logic ep, input logic es);
    @(negedge clk); evp = ep; evs = es;
    @(negedge clk); evp = 1'b0; evs = 1'b0;
  endtask

  localparam logic [7:0] CAND [16] = '{8'h04, 8'h07, 8'h09, 8'h10, 8'h11, 8'h14, 8'h1C,
    8'h20, 8'h21, 8'h50, 8'h51, 8'h53, 8'h57, 8'h5A, 8'h5B, 8'h72};

  initial begin
    logic [7:0] rn, rl;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; chk_on = 1'b1;
    chk("R13 reset rdata", {8'h00, rdata[0]}, 16'h0000);
    // R1 identification
    expect_rd("R1 vendor lo", 8'h00, 8'h95, 8'h95);
    expect_rd("R1 vendor hi", 8'h01, 8'h10, 8'h10);
    expect_rd("R1 device lo", 8'h02, 8'h46, 8'h46);
    expect_rd("R1 device hi", 8'h03, 8'h06, 8'h06);
    expect_rd("R1 class", 8'h0B, 8'h01, 8'h01);
    expect_rd("R1 int line", 8'h3C, 8'h0E, 8'h0E);
    expect_rd("R1 max lat", 8'h3F, 8'h04, 8'h04);
    do_wr(3'd0, 8'h3C, 8'hFF, 1'b0);
    expect_rd("R1 int line read-only", 8'h3C, 8'h0E, 8'h0E);
    // R10 reset image
    expect_rd("R10 chan ctl", 8'h50, 8'h40, 8'h00);
    expect_rd("R10 pri cmd lo", 8'h10, 8'hF1, 8'h00);
    expect_rd("R10 sec ctl hi", 8'h1D, 8'h03, 8'h00);
    expect_rd("R10 reg51", 8'h51, 8'h08, 8'h08);
    expect_rd("R10 reg57", 8'h57, 8'h0C, 8'h0C);
    expect_rd("R10 reg59", 8'h59, 8'h40, 8'h40);
    // R2 command
    do_wr(3'd0, 8'h04, 8'hFF, 1'b0);
    expect_rd("R2 cmd mask", 8'h04, 8'h45, 8'h45);
    // R3 status
    do_wr(3'd0, 8'h07, 8'hFF, 1'b0);
    expect_rd("R3 status hi", 8'h07, 8'h02, 8'h02);
    expect_rd("R3 status lo", 8'h06, 8'h80, 8'h80);
    // R4 programming interface
    do_wr(3'd0, 8'h09, 8'hF5, 1'b0);
    expect_rd("R4 progif", 8'h09, 8'h8F, 8'h80);
    do_wr(3'd0, 8'h09, 8'h00, 1'b0);
    expect_rd("R4 progif clear", 8'h09, 8'h8A, 8'h80);
    // R5 bases
    do_wr(3'd0, 8'h10, 8'hFF, 1'b0);
    do_wr(3'd0, 8'h14, 8'hFF, 1'b0);
    do_wr(3'd0, 8'h19, 8'hAB, 1'b0);
    expect_rd("R5 cmd lo", 8'h10, 8'hF9, 8'h00);
    expect_rd("R5 ctl lo", 8'h14, 8'hFD, 8'h00);
    expect_rd("R5 hi", 8'h19, 8'hAB, 8'h00);
    // R6 bus-master base
    do_wr(3'd0, 8'h20, 8'hFF, 1'b0);
    do_wr(3'd0, 8'h21, 8'h12, 1'b0);
    expect_rd("R6 bm lo", 8'h20, 8'hF1, 8'hF1);
    expect_rd("R6 bm hi", 8'h21, 8'h12, 8'h12);
    // R7 vendor masks
    do_wr(3'd0, 8'h51, 8'hFF, 1'b0);
    do_wr(3'd0, 8'h53, 8'hFF, 1'b0);
    do_wr(3'd0, 8'h52, 8'hFF, 1'b0);
    do_wr(3'd0, 8'h57, 8'hFF, 1'b0);
    expect_rd("R7 reg51", 8'h51, 8'hC8, 8'hC8);
    expect_rd("R7 reg53", 8'h53, 8'hC0, 8'hC0);
    expect_rd("R7 reg52", 8'h52, 8'hFF, 8'hFF);
    expect_rd("R7 reg57", 8'h57, 8'hCC, 8'hCC);
    // R11 unimplemented offsets
    do_wr(3'd0, 8'h5A, 8'hFF, 1'b0);
    do_wr(3'd0, 8'h72, 8'h40, 1'b0);
    expect_rd("R11 reg5A", 8'h5A, 8'h00, 8'h00);
    expect_rd("R11 reg72", 8'h72, 8'h00, 8'h00);
    // R8 primary interrupt
    pulse(1'b1, 1'b0);
    expect_rd("R8 set", 8'h50, 8'h44, 8'h04);
    expect_rd("R8 cleared", 8'h50, 8'h40, 8'h00);
    do_rd(3'd0, 8'h50, 1'b1, 1'b0, rn, rl);
    chk("R8 read with event", {8'h00, rn}, 16'h0040);
    expect_rd("R8 event wins", 8'h50, 8'h44, 8'h04);
    // R9 secondary interrupt
    do_wr(3'd0, 8'h57, 8'h00, 1'b1);
    expect_rd("R9 event wins write", 8'h57, 8'h10, 8'h10);
    expect_rd("R9 cleared", 8'h57, 8'h00, 8'h00);
    pulse(1'b0, 1'b1);
    do_wr(3'd0, 8'h57, 8'h0C, 1'b0);
    do_rd(3'd0, 8'h57, 1'b0, 1'b1, rn, rl);
    chk("R9 write keeps bit4", {8'h00, rn}, 16'h001C);
    expect_rd("R9 event wins read", 8'h57, 8'h1C, 8'h1C);
    // R12 other function numbers
    do_rd(3'd1, 8'h00, 1'b0, 1'b0, rn, rl);
    chk("R12 read FF", {rn, rl}, 16'hFFFF);
    do_wr(3'd2, 8'h04, 8'h00, 1'b0);
    expect_rd("R12 write ignored", 8'h04, 8'h45, 8'h45);
    // R13 hold while idle
    repeat (5) @(negedge clk);
    chk("R13 hold", {8'h00, rdata[0]}, 16'h0045);
    // Mixed traffic, compared every cycle
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      func  = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
      addr  = CAND[$urandom_range(0, 15)];
      wdata = 8'($urandom);
      rd    = ($urandom_range(0, 2) == 0);
      wr    = ($urandom_range(0, 2) == 0);
      evp   = ($urandom_range(0, 7) == 0);
      evs   = ($urandom_range(0, 7) == 0);
    end
    @(negedge clk); rd = 1'b0; wr = 1'b0; evp = 1'b0; evs = 1'b0; func = 3'd0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule